// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is a single DMA channel. Once enabled, it copies data items one at a time between a peripheral-side address and a memory-side address. It uses a simple single-beat bus master port, and it has no CPU involvement per item. In peripheral mode each item is started by a request from the peripheral and closed with a four-phase request/acknowledge handshake. In memory-to-memory mode the channel starts items by itself, back to back.

Software programs the following before setting the enable:
- the two base addresses;
- a 16-bit item count;
- a direction;
- an item width and a pointer-step enable for each side;
- an optional wrap-around (circular) mode;
- three interrupt enables.

The channel reports progress through three sticky flags: half-way, complete and error. The flags are ORed, through their enables, into one interrupt line. Arbitration between several channels and the real system bus protocol sit outside this block.

Top module: `dma_xfer_channel`

## Requirements
- R1: After a synchronous active-low reset the channel issues no bus access, holds `periph_ack` low, and has all three flags and `irq` low.
- R2: Each item is one read from the source followed by one write (`bus_write`=1) to the destination. With `cfg_to_periph`=0 the source is the peripheral side and the destination the memory side; with `cfg_to_periph`=1 it is the reverse. Width codes on `cfg_pwidth`, `cfg_mwidth` and `bus_size` are 0 = byte, 1 = half-word, 2 = word. A bus access holds its address and kind until `bus_ready`.
- R3: The first item uses the programmed bases. A side whose step enable is set advances by 1, 2 or 4 bytes per item according to that side's width. A side whose step enable is clear keeps its address.
- R4: Read data is taken from the low bits of `bus_rdata`. The written value is the read value masked to the smaller of the two widths: a wider item is truncated and a narrower one is zero-extended.
- R5: `remaining` starts at the programmed count and drops by one after each written item. `flag_half` sets once floor(N/2) items of an N-item block are written (N >= 2). `flag_done` sets when `remaining` reaches zero.
- R6: Without wrap mode the channel issues no further access after the count reaches zero until the enable is cleared and set again. A programmed count of zero issues no access at all.
- R7: In wrap mode, reaching zero reloads the count and both pointers from the programmed values, and items keep being served.
- R8: In peripheral mode an item starts only while `periph_req` is high. After the item's write the channel raises `periph_ack` and keeps it high until `periph_req` has been seen low.
- R9: Memory-to-memory mode moves items with no request and never raises `periph_ack`. Enabling it together with wrap mode sets `flag_err` and issues no access.
- R10: An address not aligned to its side's width, or width code 3, sets `flag_err` before any access, and the channel halts.
- R11: A `bus_err` on any access sets `flag_err` and halts the channel, and `remaining` is not decremented for that item.
- R12: `irq` is high exactly when a flag is set whose enable is set. `flag_clr` bit 0 clears half, bit 1 clears done and bit 2 clears error.
- R13: Clearing the enable stops the channel after the item in flight (including its handshake) completes. Setting it again restarts from the programmed bases and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_to_periph | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_mem2mem | input | 1 | Self-triggered memory-to-memory mode |
| cfg_wrap | input | 1 | Circular reload mode |
| cfg_pstep_en | input | 1 | Peripheral-side pointer step enable |
| cfg_mstep_en | input | 1 | Memory-side pointer step enable |
| cfg_pwidth | input | 2 | Peripheral-side item width |
| cfg_mwidth | input | 2 | Memory-side item width |
| cfg_count | input | CNT_W | Items per block |
| cfg_pbase | input | ADDR_W | Peripheral-side base address |
| cfg_mbase | input | ADDR_W | Memory-side base address |
| cfg_ie_half | input | 1 | Half-way interrupt enable |
| cfg_ie_done | input | 1 | Complete interrupt enable |
| cfg_ie_err | input | 1 | Error interrupt enable |
| flag_clr | input | 3 | Flag clear pulses {err, done, half} |
| periph_req | input | 1 | Peripheral request |
| periph_ack | output | 1 | Acknowledge to peripheral |
| bus_valid | output | 1 | Bus access pending |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | DATA_W | Write data, right-justified |
| bus_rdata | input | DATA_W | Read data, right-justified |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Access failed (valid with ready) |
| remaining | output | CNT_W | Items left in current block |
| flag_half | output | 1 | Half-way flag |
| flag_done | output | 1 | Complete flag |
| flag_err | output | 1 | Error flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check, on every cycle, the following properties:
- the acknowledge never drops while the request is still high;
- a stalled access keeps its address and kind;
- every issued address is aligned to its width;
- a successful write with more than one item left lowers `remaining` by exactly one;
- memory-to-memory mode never acknowledges;
- a fresh error coincides with no pending access.

Only the bench's scenarios show the exact order, addresses and data of the accesses for each direction and width pairing. They also show when the half and complete flags appear, the wrap-around reload, the stop after the last item, the behaviour on disable and re-enable, and the flag masking on `irq`.

// File: rtl/dma_xfer_pkg.sv
// Shared types for the DMA channel transfer engine.
// Assumes a bus data width of at least 32 bits so a word item fits.
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        WD_BYTE = 2'd0,
        WD_HALF = 2'd1,
        WD_WORD = 2'd2,
        WD_RSVD = 2'd3
    } item_width_e;

    typedef enum logic [2:0] {
        CH_IDLE  = 3'd0,
        CH_WAIT  = 3'd1,
        CH_READ  = 3'd2,
        CH_WRITE = 3'd3,
        CH_ACK   = 3'd4,
        CH_HALT  = 3'd5
    } chan_state_e;

endpackage

// File: rtl/dma_addr_step.sv
// Pointer helper for one side of the channel.
// Reports whether the pointer is aligned to the side's item width and
// gives the pointer for the next item (stepped by the width in bytes
// when stepping is enabled). Width code 3 counts as misaligned.
module dma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic [1:0]        width,
    input  logic              step_en,
    output logic              aligned,
    output logic [ADDR_W-1:0] ptr_next
);
    import dma_xfer_pkg::*;

    logic [ADDR_W-1:0] step_bytes;

    // Alignment test and byte step per width code.
    always_comb begin
        case (item_width_e'(width))
            WD_BYTE: begin aligned = 1'b1;               step_bytes = ADDR_W'(1); end
            WD_HALF: begin aligned = ~ptr[0];            step_bytes = ADDR_W'(2); end
            WD_WORD: begin aligned = (ptr[1:0] == 2'b00); step_bytes = ADDR_W'(4); end
            default: begin aligned = 1'b0;               step_bytes = '0;         end
        endcase
    end

    // Next pointer: stepped or held.
    always_comb ptr_next = step_en ? ptr + step_bytes : ptr;

endmodule

// File: rtl/dma_item_adapt.sv
// Width adapter between read and write sides.
// Keeps the low bits of the read item up to the narrower of the two
// widths and clears the rest, which truncates wide items and
// zero-extends narrow ones. Assumes both widths are legal codes.
module dma_item_adapt #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rd_item,
    input  logic [1:0]        src_width,
    input  logic [1:0]        dst_width,
    output logic [DATA_W-1:0] wr_item
);
    logic [1:0]        narrow;
    logic [DATA_W-1:0] keep_mask;

    // Pick the narrower width and build its byte-lane mask.
    always_comb begin
        narrow = (src_width < dst_width) ? src_width : dst_width;
        case (narrow)
            2'd0:    keep_mask = DATA_W'(8'hFF);
            2'd1:    keep_mask = DATA_W'(16'hFFFF);
            default: keep_mask = '1;
        endcase
        wr_item = rd_item & keep_mask;
    end

endmodule

// File: rtl/dma_xfer_channel.sv
// One DMA channel: moves items between a peripheral-side and a
// memory-side address over a single-beat bus master port.
// Assumes bus_rdata/bus_err are valid in the cycle bus_ready is high,
// and that configuration inputs are only changed while disabled.
// Synchronous active-low reset.
module dma_xfer_channel #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_to_periph,
    input  logic              cfg_mem2mem,
    input  logic              cfg_wrap,
    input  logic              cfg_pstep_en,
    input  logic              cfg_mstep_en,
    input  logic [1:0]        cfg_pwidth,
    input  logic [1:0]        cfg_mwidth,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic [ADDR_W-1:0] cfg_pbase,
    input  logic [ADDR_W-1:0] cfg_mbase,
    input  logic              cfg_ie_half,
    input  logic              cfg_ie_done,
    input  logic              cfg_ie_err,
    input  logic [2:0]        flag_clr,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    output logic [CNT_W-1:0]  remaining,
    output logic              flag_half,
    output logic              flag_done,
    output logic              flag_err,
    output logic              irq
);
    import dma_xfer_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    chan_state_e       state;
    logic [ADDR_W-1:0] p_ptr, m_ptr, p_base_q, m_base_q;
    logic [CNT_W-1:0]  cnt, init_q, cnt_less;
    logic [DATA_W-1:0] rd_buf, adapted;
    logic              p_ok, m_ok;
    logic [ADDR_W-1:0] p_next, m_next, src_ptr, dst_ptr;
    logic [1:0]        src_w, dst_w;

    // Per-side pointer helpers, one per side.
    dma_addr_step #(.ADDR_W(ADDR_W)) u_pside (
        .ptr(p_ptr), .width(cfg_pwidth), .step_en(cfg_pstep_en),
        .aligned(p_ok), .ptr_next(p_next)
    );
    dma_addr_step #(.ADDR_W(ADDR_W)) u_mside (
        .ptr(m_ptr), .width(cfg_mwidth), .step_en(cfg_mstep_en),
        .aligned(m_ok), .ptr_next(m_next)
    );

    // Width adapter from the captured read item to the write item.
    dma_item_adapt #(.DATA_W(DATA_W)) u_adapt (
        .rd_item(rd_buf), .src_width(src_w), .dst_width(dst_w),
        .wr_item(adapted)
    );

    // Source/destination selection from the direction bit.
    always_comb begin
        src_ptr  = cfg_to_periph ? m_ptr : p_ptr;
        dst_ptr  = cfg_to_periph ? p_ptr : m_ptr;
        src_w    = cfg_to_periph ? cfg_mwidth : cfg_pwidth;
        dst_w    = cfg_to_periph ? cfg_pwidth : cfg_mwidth;
        cnt_less = cnt - ONE;
    end

    // Channel sequencer, pointers, count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CH_IDLE;
            p_ptr     <= '0;
            m_ptr     <= '0;
            p_base_q  <= '0;
            m_base_q  <= '0;
            cnt       <= '0;
            init_q    <= '0;
            rd_buf    <= '0;
            flag_half <= 1'b0;
            flag_done <= 1'b0;
            flag_err  <= 1'b0;
        end else begin
            if (flag_clr[0]) flag_half <= 1'b0;
            if (flag_clr[1]) flag_done <= 1'b0;
            if (flag_clr[2]) flag_err  <= 1'b0;
            case (state)
                CH_IDLE: if (cfg_enable) begin
                    p_base_q <= cfg_pbase;
                    m_base_q <= cfg_mbase;
                    p_ptr    <= cfg_pbase;
                    m_ptr    <= cfg_mbase;
                    init_q   <= cfg_count;
                    cnt      <= cfg_count;
                    state    <= CH_WAIT;
                end
                CH_WAIT: begin
                    if (!cfg_enable) begin
                        state <= CH_IDLE;
                    end else if (cfg_mem2mem && cfg_wrap) begin
                        flag_err <= 1'b1;
                        state    <= CH_HALT;
                    end else if (cnt == '0) begin
                        state <= CH_HALT;
                    end else if (!p_ok || !m_ok) begin
                        flag_err <= 1'b1;
                        state    <= CH_HALT;
                    end else if (cfg_mem2mem || periph_req) begin
                        state <= CH_READ;
                    end
                end
                CH_READ: if (bus_ready) begin
                    if (bus_err) begin
                        flag_err <= 1'b1;
                        state    <= CH_HALT;
                    end else begin
                        rd_buf <= bus_rdata;
                        state  <= CH_WRITE;
                    end
                end
                CH_WRITE: if (bus_ready) begin
                    if (bus_err) begin
                        flag_err <= 1'b1;
                        state    <= CH_HALT;
                    end else begin
                        if (init_q >= TWO && cnt_less == init_q - (init_q >> 1))
                            flag_half <= 1'b1;
                        if (cnt_less == '0) begin
                            flag_done <= 1'b1;
                        end
                        if (cnt_less == '0 && cfg_wrap) begin
                            cnt   <= init_q;
                            p_ptr <= p_base_q;
                            m_ptr <= m_base_q;
                        end else begin
                            cnt   <= cnt_less;
                            p_ptr <= p_next;
                            m_ptr <= m_next;
                        end
                        state <= cfg_mem2mem ? CH_WAIT : CH_ACK;
                    end
                end
                CH_ACK:  if (!periph_req) state <= CH_WAIT;
                CH_HALT: if (!cfg_enable) state <= CH_IDLE;
                default: state <= CH_IDLE;
            endcase
        end
    end

    // Bus, handshake and interrupt outputs.
    always_comb begin
        bus_valid  = (state == CH_READ) || (state == CH_WRITE);
        bus_write  = (state == CH_WRITE);
        bus_addr   = bus_write ? dst_ptr : src_ptr;
        bus_size   = bus_write ? dst_w : src_w;
        bus_wdata  = adapted;
        periph_ack = (state == CH_ACK);
        remaining  = cnt;
        irq        = (flag_half & cfg_ie_half) | (flag_done & cfg_ie_done)
                   | (flag_err & cfg_ie_err);
    end

endmodule

// File: rtl/dma_xfer_channel_chk.sv
// Property checker for the DMA channel, bound to every instance.
// Observes ports only; all properties are disabled during reset.
module dma_xfer_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mem2mem,
    input logic              periph_req,
    input logic              periph_ack,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_ready,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [CNT_W-1:0]  remaining,
    input logic              flag_err
);
    // R8: acknowledge is held while the request is still high.
    a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack && periph_req |=> periph_ack);

    // R2: a stalled access keeps its kind and address.
    a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    // R10: every issued address is aligned to its width code.
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_size == 2'd0) || (bus_size == 2'd1 && !bus_addr[0])
                      || (bus_size == 2'd2 && bus_addr[1:0] == 2'b00));

    // R5: a good write with more than one item left lowers the count by one.
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && bus_ready && !bus_err && remaining > CNT_W'(1)
        |=> remaining == $past(remaining) - CNT_W'(1));

    // R9: memory-to-memory mode never acknowledges.
    a_r9_m2m_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mem2mem |-> !periph_ack);

    // R11: a newly raised error leaves no access pending.
    a_r11_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_err) |-> !bus_valid);

endmodule

bind dma_xfer_channel dma_xfer_channel_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mem2mem(cfg_mem2mem),
    .periph_req(periph_req), .periph_ack(periph_ack),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_addr(bus_addr), .bus_size(bus_size),
    .remaining(remaining), .flag_err(flag_err)
);

// File: tb/dma_xfer_channel_tb.sv
// Bench: behavioural model of expected accesses, compared at every clock.
module dma_xfer_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 0, cfg_to_periph = 0, cfg_mem2mem = 0, cfg_wrap = 0;
    logic        cfg_pstep_en = 0, cfg_mstep_en = 0;
    logic [1:0]  cfg_pwidth = 0, cfg_mwidth = 0;
    logic [15:0] cfg_count = 0;
    logic [31:0] cfg_pbase = 0, cfg_mbase = 0;
    logic        cfg_ie_half = 0, cfg_ie_done = 0, cfg_ie_err = 0;
    logic [2:0]  flag_clr = 0;
    logic        periph_req = 0, periph_ack;
    logic        bus_valid, bus_write, bus_ready = 0, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic [15:0] remaining;
    logic        flag_half, flag_done, flag_err, irq;

    always #4 clk = ~clk;

    dma_xfer_channel u_dut (.*);

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [31:0] data;
        int          rem;
        bit          half;
        bit          done;
    } acc_t;

    acc_t q[$];
    int   n_cmp = 0, n_bad = 0, cyc = 0;
    int   rd_seen = 0, ack_cnt = 0;
    bit   pm_on = 0, err_on = 0, ack_prev = 0, pend = 0;
    logic [31:0] err_addr = 0;
    int   rdy_ph = 0, pst = 0;
    acc_t pend_e;

    function automatic logic [31:0] rdfn(logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] wmask(logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    assign bus_rdata = rdfn(bus_addr);
    assign bus_err   = err_on && bus_valid && !bus_write && (bus_addr == err_addr);

    // Ready pattern: stall one cycle in three.
    always @(posedge clk) begin
        #1;
        rdy_ph  = (rdy_ph + 1) % 3;
        bus_ready = (rdy_ph != 0);
    end

    // Peripheral model with four-phase handshake.
    always @(posedge clk) begin
        #1;
        if (!pm_on) begin
            periph_req = 0; pst = 0;
        end else begin
            case (pst)
                0: begin periph_req = 1; pst = 1; end
                1: if (periph_ack) begin periph_req = 0; pst = 2; end
                default: if (!periph_ack) pst = 0;
            endcase
        end
    end

    // Monitor: compares each completing access with the model queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                pend = 0;
                chk("R5 remaining", 32'(remaining), 32'(pend_e.rem));
                chk("R5 half flag", 32'(flag_half), 32'(pend_e.half));
                chk("R5 done flag", 32'(flag_done), 32'(pend_e.done));
            end
            if (periph_ack && !ack_prev) ack_cnt++;
            ack_prev = periph_ack;
            if (bus_valid && bus_ready) begin
                if (!bus_write) rd_seen++;
                if (q.size() == 0) begin
                    chk("R6 unexpected access", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    e = q.pop_front();
                    chk("R2 access kind", 32'(bus_write), 32'(e.wr));
                    chk("R3 address", bus_addr, e.addr);
                    chk("R2 size", 32'(bus_size), 32'(e.sz));
                    if (e.wr) begin
                        chk("R4 write data", bus_wdata, e.data);
                        pend = 1; pend_e = e;
                    end
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Build the expected access list for `items` items from the bases.
    task automatic build(input int n, input int items, input bit wrap);
        for (int k = 0; k < items; k++) begin
            acc_t r, w;
            int j;
            logic [31:0] p, m, s, d;
            logic [1:0] sw, dw;
            j  = k % n;
            p  = cfg_pbase + (cfg_pstep_en ? (j << cfg_pwidth) : 0);
            m  = cfg_mbase + (cfg_mstep_en ? (j << cfg_mwidth) : 0);
            s  = cfg_to_periph ? m : p;
            d  = cfg_to_periph ? p : m;
            sw = cfg_to_periph ? cfg_mwidth : cfg_pwidth;
            dw = cfg_to_periph ? cfg_pwidth : cfg_mwidth;
            r = '{wr: 0, addr: s, sz: sw, data: 0, rem: 0, half: 0, done: 0};
            w.wr = 1; w.addr = d; w.sz = dw;
            w.data = rdfn(s) & wmask((sw < dw) ? sw : dw);
            w.rem  = (wrap && j == n - 1) ? n : n - j - 1;
            w.half = (n >= 2) && (k >= n || (j + 1) >= n / 2);
            w.done = (k >= n - 1);
            q.push_back(r);
            q.push_back(w);
        end
    endtask

    task automatic fresh();
        cfg_enable = 0; pm_on = 0; err_on = 0;
        repeat (6) @(negedge clk);
        flag_clr = 3'b111;
        @(negedge clk);
        flag_clr = 3'b000;
        q.delete(); rd_seen = 0; ack_cnt = 0;
    endtask

    task automatic drain();
        int t = 0;
        while (q.size() != 0 && t < 3000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic setup(input bit tp, input bit m2m, input bit wrp, input bit ps, input bit ms,
                         input logic [1:0] pw, input logic [1:0] mw, input int n,
                         input logic [31:0] pb, input logic [31:0] mb);
        cfg_to_periph = tp; cfg_mem2mem = m2m; cfg_wrap = wrp;
        cfg_pstep_en = ps; cfg_mstep_en = ms; cfg_pwidth = pw; cfg_mwidth = mw;
        cfg_count = 16'(n); cfg_pbase = pb; cfg_mbase = mb;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk("R1 bus idle", 32'(bus_valid), 0);
        chk("R1 ack low", 32'(periph_ack), 0);
        chk("R1 flags", {29'd0, flag_err, flag_done, flag_half}, 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1;

        // Peripheral to memory, word to byte, fixed periph address.
        fresh();
        setup(0, 0, 0, 0, 1, 2'd2, 2'd0, 4, 32'h4000_0010, 32'h2000_0100);
        cfg_ie_half = 1; cfg_ie_done = 1; cfg_ie_err = 0;
        build(4, 4, 0);
        pm_on = 1; cfg_enable = 1;
        drain();
        chk("R6 all items moved", q.size(), 0);
        chk("R8 one ack per item", ack_cnt, 4);
        chk("R5 count at zero", 32'(remaining), 0);
        chk("R12 irq with done enabled", 32'(irq), 1);

        // Memory to peripheral, half to word, both stepping.
        fresh();
        setup(1, 0, 0, 1, 1, 2'd2, 2'd1, 3, 32'h4000_0100, 32'h2000_0202);
        build(3, 3, 0);
        pm_on = 1; cfg_enable = 1;
        drain();
        chk("R2 reverse direction done", q.size(), 0);
        chk("R8 acks", ack_cnt, 3);

        // Memory to memory, no request, interrupts masked.
        fresh();
        setup(0, 1, 0, 1, 1, 2'd2, 2'd2, 5, 32'h1000_0000, 32'h2000_0400);
        cfg_ie_half = 0; cfg_ie_done = 0;
        build(5, 5, 0);
        cfg_enable = 1;
        drain();
        chk("R9 self-triggered items", q.size(), 0);
        chk("R9 no ack", ack_cnt, 0);
        chk("R12 done set", 32'(flag_done), 1);
        chk("R12 irq masked", 32'(irq), 0);

        // Circular mode, disable after fifth read.
        fresh();
        setup(0, 0, 1, 0, 1, 2'd1, 2'd1, 2, 32'h4000_0020, 32'h2000_0800);
        build(2, 5, 1);
        pm_on = 1; cfg_enable = 1;
        do begin @(negedge clk); #2; end while (rd_seen < 5);
        cfg_enable = 0;
        drain();
        chk("R7 wrap items served", q.size(), 0);
        chk("R13 stop after item in flight", rd_seen, 5);

        // Re-enable without wrap: restarts from bases.
        q.delete(); rd_seen = 0;
        cfg_wrap = 0;
        flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
        build(2, 2, 0);
        cfg_enable = 1;
        drain();
        chk("R13 reload from base", q.size(), 0);
        chk("R6 halted at zero", rd_seen, 2);

        // Misaligned memory address.
        fresh();
        setup(0, 0, 0, 0, 1, 2'd0, 2'd2, 4, 32'h4000_0000, 32'h2000_0102);
        cfg_ie_err = 1;
        pm_on = 1; cfg_enable = 1;
        drain();
        chk("R10 error flag", 32'(flag_err), 1);
        chk("R10 no access", rd_seen, 0);
        chk("R12 irq on error", 32'(irq), 1);

        // Memory-to-memory with wrap is rejected.
        fresh();
        setup(0, 1, 1, 1, 1, 2'd2, 2'd2, 4, 32'h1000_0000, 32'h2000_0000);
        cfg_enable = 1;
        drain();
        chk("R9 m2m+wrap error", 32'(flag_err), 1);
        chk("R9 m2m+wrap no access", rd_seen, 0);

        // Zero count.
        fresh();
        setup(0, 1, 0, 1, 1, 2'd2, 2'd2, 0, 32'h1000_0000, 32'h2000_0000);
        cfg_enable = 1;
        drain();
        chk("R6 zero count no access", rd_seen, 0);
        chk("R6 zero count no error", 32'(flag_err), 0);

        // Bus error on first read.
        fresh();
        setup(0, 1, 0, 1, 1, 2'd2, 2'd2, 3, 32'h1000_0040, 32'h2000_0000);
        err_on = 1; err_addr = 32'h1000_0040;
        q.push_back('{wr: 0, addr: 32'h1000_0040, sz: 2'd2, data: 0, rem: 0, half: 0, done: 0});
        cfg_enable = 1;
        drain();
        chk("R11 error flag", 32'(flag_err), 1);
        chk("R11 count kept", 32'(remaining), 3);
        chk("R11 one access", rd_seen, 1);

        // Flag clear.
        flag_clr = 3'b100; @(negedge clk); flag_clr = 3'b000; @(negedge clk);
        chk("R12 error cleared", 32'(flag_err), 0);
        chk("R12 irq low after clear", 32'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule